// File: doc/BRIEF.md
# Static Latency-Insensitive Block Wrapper

This block sits around a synchronous computation core that has two input channels and one output channel, all of which use a valid/stop handshake. Each input channel feeds a small token queue. A cycle in which the sender drives valid low carries a void token, and void tokens are never stored. The core advances only through a clock enable. The enable is raised in a cycle when both queues hold a token and the downstream side is not holding back a valid result. When that happens, one token leaves each queue in the same cycle.

When the core cannot advance because an input token is missing, the output channel carries void. When the receiver raises stop against a valid result, the result is held in place and stop is broadcast to both input channels. A stop raised against a void output is absorbed. Each queue raises stop on its own channel while it is full. The core inside is a registered modulo-2^DATA_W adder, which stands in for any single-cycle core.

Top module: `lipWrapper`

## Requirements
- R1: After reset, outValid is 0 and both aStop and bStop are 0.
- R2: A cycle with aValid (or bValid) at 0 stores nothing, so its data never contributes to any result.
- R3: The core fires only in a cycle when both queues hold a token. The result appears on outValid/outData in the next cycle. A queue with no partner token yields no output.
- R4: Each firing consumes exactly one token from each queue. The sequence of valid results delivered (outValid=1 and outStop=0) equals the pairwise sums of the accepted A and B tokens, taken in acceptance order.
- R5: In a cycle after a stall caused by a missing input token, outValid is 0.
- R6: While a queue holds FIFO_DEPTH tokens (default 2), the stop line of its channel is 1.
- R7: When outStop is 1 while outValid is 1, both aStop and bStop are 1 in that cycle. In the following cycle outValid stays 1 and outData is unchanged.
- R8: When outStop is 1 while outValid is 0, aStop and bStop are not raised by it, and the core still fires if both queues hold a token.
- R9: A token offered while its channel's stop is 1 is not accepted. A token offered while stop is 0 is accepted at that clock edge.
- R10: Results are taken modulo 2^DATA_W (DATA_W default 8): 200+100 gives 44.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| aValid | input | 1 | Channel A token is valid (0 = void) |
| aData | input | DATA_W | Channel A token data |
| aStop | output | 1 | Stop towards the channel A sender |
| bValid | input | 1 | Channel B token is valid (0 = void) |
| bData | input | DATA_W | Channel B token data |
| bStop | output | 1 | Stop towards the channel B sender |
| outValid | output | 1 | Output token is valid (0 = void) |
| outData | output | DATA_W | Output token data (core result) |
| outStop | input | 1 | Stop from the output receiver |

## Verification
A queue whose occupancy goes wrong shows up first at its stop line, because a full flag set too late or too early changes aStop or bStop on the next cycle. Lost or duplicated tokens shift every later result, so the first mismatching sum is delivered within a few cycles of the fault. A broken hold under stop shows up one cycle later, as a changed outData or a dropped outValid while outStop is high. A misfire on a missing token shows up as a result that has no accepted pair behind it. A reference scoreboard built from accepted tokens catches both of these last faults, under random input gaps and random stop patterns.

// File: rtl/lipWrapPkg.sv
package lipWrapPkg;
  parameter int unsigned NUM_IN = 2;

  // strobes from control to datapath
  typedef struct packed {
    logic              fire;
    logic [NUM_IN-1:0] push;
  } strobe_t;

  // queue state from datapath to control
  typedef struct packed {
    logic [NUM_IN-1:0] full;
    logic [NUM_IN-1:0] empty;
  } status_t;
endpackage

// File: rtl/tokenFifo.sv
module tokenFifo #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              full,
  output logic              empty
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  cntQ, cntNext;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign cntNext = cntQ + CNT_W'(push) - CNT_W'(pop);
  assign rdData  = mem[rdPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      cntQ  <= '0;
      full  <= 1'b0;
      empty <= 1'b1;
    end else begin
      if (push) wrPtr <= nextPtr(wrPtr);
      if (pop)  rdPtr <= nextPtr(rdPtr);
      cntQ  <= cntNext;
      full  <= (cntNext == CNT_W'(DEPTH));
      empty <= (cntNext == '0);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= wrData;
  end
endmodule

// File: rtl/sumPearl.sv
module sumPearl #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NUM_IN = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          en,
  input  logic [NUM_IN-1:0][DATA_W-1:0] operand,
  output logic [DATA_W-1:0]             result
);
  logic [DATA_W-1:0] sumComb;

  always_comb begin
    sumComb = '0;
    for (int i = 0; i < int'(NUM_IN); i++) sumComb = sumComb + operand[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)   result <= '0;
    else if (en) result <= sumComb;
  end
endmodule

// File: rtl/wrapDatapath.sv
module wrapDatapath
  import lipWrapPkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned FIFO_DEPTH = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  strobe_t                       strb,
  input  logic [NUM_IN-1:0][DATA_W-1:0] inData,
  output status_t                       stat,
  output logic [DATA_W-1:0]             outData
);
  logic [NUM_IN-1:0][DATA_W-1:0] headData;

  for (genvar g = 0; g < int'(NUM_IN); g++) begin : gQueue
    tokenFifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) uFifo (
      .clk    (clk),
      .rstN   (rstN),
      .push   (strb.push[g]),
      .pop    (strb.fire),
      .wrData (inData[g]),
      .rdData (headData[g]),
      .full   (stat.full[g]),
      .empty  (stat.empty[g])
    );
  end

  sumPearl #(.DATA_W(DATA_W), .NUM_IN(NUM_IN)) uPearl (
    .clk     (clk),
    .rstN    (rstN),
    .en      (strb.fire),
    .operand (headData),
    .result  (outData)
  );
endmodule

// File: rtl/wrapCtrl.sv
module wrapCtrl
  import lipWrapPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_IN-1:0] inValid,
  input  logic              outStop,
  input  status_t           stat,
  output logic [NUM_IN-1:0] inStop,
  output strobe_t           strb,
  output logic              outValid
);
  logic holdOut;
  logic allReady;

  // stop only counts when it lands on a valid result
  assign holdOut   = outStop & outValid;
  assign allReady  = &(~stat.empty);
  assign strb.fire = allReady & ~holdOut;
  assign inStop    = stat.full | {NUM_IN{holdOut}};
  assign strb.push = inValid & ~inStop;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= strb.fire | holdOut;
  end
endmodule

// File: rtl/lipWrapper.sv
module lipWrapper
  import lipWrapPkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned FIFO_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              aValid,
  input  logic [DATA_W-1:0] aData,
  output logic              aStop,
  input  logic              bValid,
  input  logic [DATA_W-1:0] bData,
  output logic              bStop,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  input  logic              outStop
);
  strobe_t                       strbBus;
  status_t                       statBus;
  logic [NUM_IN-1:0]             inStopVec;
  logic [NUM_IN-1:0][DATA_W-1:0] inDataVec;

  assign inDataVec = {bData, aData};
  assign aStop     = inStopVec[0];
  assign bStop     = inStopVec[1];

  wrapCtrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  ({bValid, aValid}),
    .outStop  (outStop),
    .stat     (statBus),
    .inStop   (inStopVec),
    .strb     (strbBus),
    .outValid (outValid)
  );

  wrapDatapath #(.DATA_W(DATA_W), .FIFO_DEPTH(FIFO_DEPTH)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strbBus),
    .inData  (inDataVec),
    .stat    (statBus),
    .outData (outData)
  );
endmodule

// File: rtl/lipWrapperChk.sv
module lipWrapperChk
  import lipWrapPkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              aValid,
  input logic              aStop,
  input logic              bValid,
  input logic              bStop,
  input logic              outValid,
  input logic [DATA_W-1:0] outData,
  input logic              outStop,
  input logic [NUM_IN-1:0] fifoFull,
  input logic [NUM_IN-1:0] fifoEmpty
);
  // R7: a stopped valid result stays put
  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outStop |=> outValid && $stable(outData));

  // R7: stop on a valid result reaches both inputs
  a_r7_broadcast: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outStop |-> aStop && bStop);

  // R8: stop on a void output is absorbed
  a_r8_swallow: assert property (@(posedge clk) disable iff (!rstN)
    !outValid && outStop && !fifoFull[0] && !fifoFull[1] |-> !aStop && !bStop);

  // R3: a fresh result needs a token in each queue one cycle earlier
  a_r3_fire_needs_tokens: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> $past(!fifoEmpty[0] && !fifoEmpty[1]));

  // R9: an accepted token lands in its queue
  a_r9_accept_a: assert property (@(posedge clk) disable iff (!rstN)
    aValid && !aStop |=> !fifoEmpty[0]);
  a_r9_accept_b: assert property (@(posedge clk) disable iff (!rstN)
    bValid && !bStop |=> !fifoEmpty[1]);
endmodule

bind lipWrapper lipWrapperChk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .aValid    (aValid),
  .aStop     (aStop),
  .bValid    (bValid),
  .bStop     (bStop),
  .outValid  (outValid),
  .outData   (outData),
  .outStop   (outStop),
  .fifoFull  (statBus.full),
  .fifoEmpty (statBus.empty)
);

// File: tb/sim_lipWrapper.sv
`timescale 1ns/1ps
module sim_lipWrapper;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          aValid = 1'b0, bValid = 1'b0, outStop = 1'b0;
  logic [DW-1:0] aData = '0, bData = '0;
  logic          aStop, bStop, outValid;
  logic [DW-1:0] outData;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 1'b0;
  logic [DW-1:0] qa[$];
  logic [DW-1:0] qb[$];

  always #10 clk = ~clk;

  lipWrapper #(.DATA_W(DW), .FIFO_DEPTH(2)) u0 (
    .clk(clk), .rstN(rstN),
    .aValid(aValid), .aData(aData), .aStop(aStop),
    .bValid(bValid), .bData(bData), .bStop(bStop),
    .outValid(outValid), .outData(outData), .outStop(outStop)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference: pair accepted tokens in order, sum modulo 2^DW
  always @(negedge clk) begin
    if (!rstN) begin
      qa.delete();
      qb.delete();
    end else begin
      if (outValid && !outStop) begin
        if (qa.size() == 0 || qb.size() == 0)
          check(1'b0, "R3 result without a token pair", int'(outData), -1);
        else begin
          logic [DW-1:0] ev;
          ev = qa.pop_front() + qb.pop_front();
          check(outData == ev, "R4 result sequence", int'(outData), int'(ev));
        end
      end
      if (aValid && !aStop) qa.push_back(aData);
      if (bValid && !bStop) qb.push_back(bData);
    end
  end

  task automatic doReset();
    rstN = 1'b0;
    aValid = 0; bValid = 0; outStop = 0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
  endtask

  // one cycle: drive after the edge, sample at the falling edge
  task automatic cyc(input bit av, input int ad, input bit bv, input int bd, input bit os);
    @(posedge clk); #1;
    aValid = av; aData = DW'(ad);
    bValid = bv; bData = DW'(bd);
    outStop = os;
    @(negedge clk);
  endtask

  // fields: aValid, aData, bValid, bData, outStop
  typedef struct packed { logic av; logic [7:0] ad; logic bv; logic [7:0] bd; logic os; } vec_t;
  localparam vec_t VEC [16] = '{
    '{1'b1, 8'd5,   1'b1, 8'd7,   1'b0},
    '{1'b1, 8'd9,   1'b0, 8'd88,  1'b0},
    '{1'b0, 8'd66,  1'b1, 8'd3,   1'b0},
    '{1'b1, 8'd200, 1'b1, 8'd100, 1'b0},
    '{1'b1, 8'd255, 1'b1, 8'd1,   1'b1},
    '{1'b0, 8'd0,   1'b0, 8'd0,   1'b1},
    '{1'b1, 8'd17,  1'b0, 8'd0,   1'b0},
    '{1'b1, 8'd18,  1'b0, 8'd0,   1'b0},
    '{1'b1, 8'd19,  1'b0, 8'd0,   1'b0},
    '{1'b0, 8'd0,   1'b1, 8'd40,  1'b0},
    '{1'b0, 8'd0,   1'b1, 8'd41,  1'b1},
    '{1'b0, 8'd0,   1'b1, 8'd42,  1'b0},
    '{1'b1, 8'd128, 1'b1, 8'd128, 1'b0},
    '{1'b0, 8'd1,   1'b0, 8'd2,   1'b1},
    '{1'b1, 8'd60,  1'b1, 8'd70,  1'b0},
    '{1'b0, 8'd0,   1'b0, 8'd0,   1'b0}
  };

  initial begin
    bit aTaken, bTaken;

    // R1 reset state
    doReset();
    check(outValid == 1'b0, "R1 outValid after reset", outValid, 0);
    check(aStop == 1'b0 && bStop == 1'b0, "R1 stops after reset", {aStop, bStop}, 0);

    // directed walk through fill, stall, hold and swallowed stop
    cyc(1, 1, 0, 99, 0);
    cyc(1, 2, 0, 77, 0);               // R2: 99 and 77 are voids
    cyc(1, 3, 0, 0, 0);
    check(aStop == 1'b1, "R6 full queue raises aStop", aStop, 1);
    check(bStop == 1'b0, "R6 bStop stays low", bStop, 0);
    check(outValid == 1'b0, "R5 void while B is empty", outValid, 0);
    cyc(1, 3, 1, 10, 0);
    check(aStop == 1'b1, "R9 token held under stop", aStop, 1);
    check(outValid == 1'b0, "R3 no result before pair present", outValid, 0);
    cyc(1, 3, 1, 20, 0);
    check(outValid == 1'b0, "R3 result is one cycle after firing", outValid, 0);
    cyc(1, 3, 0, 0, 0);
    check(outValid == 1'b1 && outData == 8'd11, "R2 R4 first sum ignores voids", int'(outData), 11);
    check(aStop == 1'b0, "R9 aStop drops after a pop", aStop, 0);
    cyc(0, 0, 1, 30, 1);
    check(outValid == 1'b1 && outData == 8'd22, "R4 second sum", int'(outData), 22);
    check(aStop == 1'b1 && bStop == 1'b1, "R7 stop broadcast to inputs", {aStop, bStop}, 3);
    cyc(0, 0, 1, 30, 0);
    check(outValid == 1'b1 && outData == 8'd22, "R7 result held under stop", int'(outData), 22);
    check(bStop == 1'b0, "R7 broadcast ends with stop", bStop, 0);
    cyc(0, 0, 0, 0, 1);
    check(outValid == 1'b0, "R5 void after stall on empty B", outValid, 0);
    check(aStop == 1'b0 && bStop == 1'b0, "R8 stop on void is swallowed", {aStop, bStop}, 0);
    cyc(0, 0, 0, 0, 0);
    check(outValid == 1'b1 && outData == 8'd33, "R8 core fired despite stop on void", int'(outData), 33);
    cyc(0, 0, 0, 0, 0);

    // R10 wrap
    doReset();
    cyc(1, 200, 1, 100, 0);
    cyc(0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);
    check(outValid == 1'b1 && outData == 8'd44, "R10 modulo sum", int'(outData), 44);
    cyc(0, 0, 0, 0, 0);

    // table walk; the scoreboard supplies expected sums
    doReset();
    foreach (VEC[i]) cyc(VEC[i].av, int'(VEC[i].ad), VEC[i].bv, int'(VEC[i].bd), VEC[i].os);
    repeat (8) cyc(0, 0, 0, 0, 0);
    check(qa.size() == 0 || qb.size() == 0, "R3 table pairs all delivered",
          int'(qa.size() < qb.size() ? qa.size() : qb.size()), 0);

    // random gaps and stops, senders hold tokens until accepted
    doReset();
    aTaken = 0; bTaken = 0;
    for (int i = 0; i < 3000; i++) begin
      @(posedge clk); #1;
      if (!aValid || aTaken) begin aValid = ($urandom % 3) != 0; aData = DW'($urandom); end
      if (!bValid || bTaken) begin bValid = ($urandom % 3) != 0; bData = DW'($urandom); end
      outStop = ($urandom % 4) == 0;
      @(negedge clk);
      aTaken = aValid && !aStop;
      bTaken = bValid && !bStop;
    end
    repeat (10) cyc(0, 0, 0, 0, 0);
    check(qa.size() == 0 || qb.size() == 0, "R3 random pairs all delivered",
          int'(qa.size() < qb.size() ? qa.size() : qb.size()), 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule